// File: doc/BRIEF.md
# Datapath ALU with Signed Compare

This block is the arithmetic and logic unit of a small load/store RISC datapath. It is purely combinational: two 32-bit operands go in, and a 32-bit result and a negative flag come out in the same cycle. In normal operation a 3-bit operation code selects addition, subtraction or one of three bitwise operations.

A test flag switches the unit into compare mode. It subtracts the second operand from the first. The same 3-bit code then serves as a greater/equal/less mask over the sign and zero of the difference, and the result is a single bit in position 0. A forced-add flag makes the unit add, whatever the code and the test flag. The datapath uses this for effective addresses, branch targets and saved return addresses.

Top module: `rv_alu`

## Requirements
- R1: With the test flag and the forced-add flag both low, operation code 3'b011 gives `a + b` and 3'b010 gives `a - b`, both modulo 2^32.
- R2: Subtraction is formed as `a + ~b + 1`, so `a - b` wraps modulo 2^32 for every operand pair, including the most negative value.
- R3: With both flags low, code 3'b110 gives `a & b`, 3'b101 gives `a | b` and 3'b100 gives `a ^ b`.
- R4: When the forced-add flag is high, the result is `a + b` for any operation code and either value of the test flag.
- R5: When the test flag is high and the forced-add flag is low, result bits 31..1 are zero.
- R6: In compare mode, code bit 0 selects a>b, bit 1 selects a==b and bit 2 selects a<b, all signed. Result bit 0 is the OR of the selected relations. This gives 001 gt, 010 eq, 011 ge, 100 lt, 101 ne and 110 le.
- R7: In compare mode, codes 3'b000 and 3'b111 give a result of 0.
- R8: The negative flag is the sign of the exact two's-complement value. That value is a-b when subtracting (code 3'b010, or compare mode without forced add) and a+b otherwise. Overflow does not corrupt the sign.
- R9: With both flags low, codes 3'b000, 3'b001 and 3'b111 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code, or compare mask in compare mode |
| cmp_mode | input | 1 | Selects compare mode |
| add_force | input | 1 | Forces addition, overriding code and compare mode |
| res | output | 32 | Result |
| neg | output | 1 | Sign of the exact sum or difference |

## Verification
The bound checker evaluates its checks on every change of the inputs. It confirms that the upper bits are cleared in compare mode and that forced add always returns the sum. It checks the equality compare against operand equality, the AND code and the overflow-corrected sign of a subtraction. Other behaviour needs the bench's scenarios. This covers each of the six compare masks and the two dead masks, the sign correction at the overflow boundaries, and the zero result of unused codes. The bench drives these alongside random operands and compares them against a model built on wide signed integers.

// File: rtl/rv_alu.sv
module rv_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic         cmp_mode,
  input  logic         add_force,
  output logic [W-1:0] res,
  output logic         neg
);
  localparam logic [2:0] OP_ADD = 3'b011;
  localparam logic [2:0] OP_SUB = 3'b010;
  localparam logic [2:0] OP_AND = 3'b110;
  localparam logic [2:0] OP_OR  = 3'b101;
  localparam logic [2:0] OP_XOR = 3'b100;

  logic         do_sub;
  logic [W-1:0] b_x;
  logic [W-1:0] sum;
  logic         ovf, zero, hit;

  assign do_sub = !add_force && (cmp_mode || op_sel == OP_SUB);
  assign b_x    = op_b ^ {W{do_sub}};
  assign sum    = op_a + b_x + {{(W-1){1'b0}}, do_sub};
  assign ovf    = (op_a[W-1] == b_x[W-1]) && (sum[W-1] != op_a[W-1]);
  assign neg    = sum[W-1] ^ ovf;
  assign zero   = (sum == '0);
  assign hit    = (op_sel != 3'b111) &&
                  ((op_sel[0] && !neg && !zero) || (op_sel[1] && zero) || (op_sel[2] && neg));

  always_comb begin
    if (add_force)     res = sum;
    else if (cmp_mode) res = {{(W-1){1'b0}}, hit};
    else begin
      unique case (op_sel)
        OP_ADD, OP_SUB: res = sum;
        OP_AND:         res = op_a & op_b;
        OP_OR:          res = op_a | op_b;
        OP_XOR:         res = op_a ^ op_b;
        default:        res = '0;
      endcase
    end
  end
endmodule

// File: rtl/rv_alu_chk.sv
module rv_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   op_sel,
  input logic         cmp_mode,
  input logic         add_force,
  input logic [W-1:0] res,
  input logic         neg
);
  always_comb begin
    if (cmp_mode && !add_force)
      AST_CMP_UPPER_CLEAR: assert (res[W-1:1] == '0) else $error("upper bits set"); // R5
    if (add_force)
      AST_FORCED_SUM: assert (res == W'(op_a + op_b)) else $error("forced add wrong"); // R4
    if (cmp_mode && !add_force && op_sel == 3'b010)
      AST_CMP_EQ: assert (res[0] == (op_a == op_b)) else $error("eq compare wrong"); // R6
    if (!add_force && (cmp_mode || op_sel == 3'b010))
      AST_SUB_SIGN: assert (neg == ($signed(op_a) < $signed(op_b))) else $error("sign wrong"); // R8
    if (!add_force && !cmp_mode && op_sel == 3'b110)
      AST_AND_OP: assert (res == (op_a & op_b)) else $error("and wrong"); // R3
  end
endmodule

bind rv_alu rv_alu_chk #(.W(W)) u_chk (.*);

// File: tb/rv_alu_bench.sv
module rv_alu_bench;
  logic clk = 0;
  always #4 clk = ~clk;

  logic [31:0] a, b, r;
  logic [2:0]  sel;
  logic        cm, fa, n;
  int errors = 0, checks = 0, cyc = 0;

  rv_alu u_rv_alu (.op_a(a), .op_b(b), .op_sel(sel), .cmp_mode(cm), .add_force(fa), .res(r), .neg(n));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic model(input logic [31:0] x, y, input logic [2:0] s, input logic c, f,
                       output logic [31:0] er, output logic en);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint v;
    bit sub = !f && (c || s == 3'b010);
    v = sub ? sx - sy : sx + sy;
    en = (v < 0);
    if (f) er = 32'(v);
    else if (c) begin
      bit g = sx > sy, e = sx == sy, l = sx < sy;
      case (s)
        3'b001: er = {31'd0, g};
        3'b010: er = {31'd0, e};
        3'b011: er = {31'd0, g | e};
        3'b100: er = {31'd0, l};
        3'b101: er = {31'd0, !e};
        3'b110: er = {31'd0, l | e};
        default: er = 0;
      endcase
    end else case (s)
      3'b011, 3'b010: er = 32'(v);
      3'b110: er = x & y;
      3'b101: er = x | y;
      3'b100: er = x ^ y;
      default: er = 0;
    endcase
  endtask

  task automatic run(input logic [31:0] x, y, input logic [2:0] s, input logic c, f, input string tag);
    logic [31:0] er; logic en;
    @(posedge clk);
    a = x; b = y; sel = s; cm = c; fa = f;
    model(x, y, s, c, f, er, en);
    @(negedge clk);
    checks++;
    if (r !== er || n !== en) begin
      errors++;
      $display("FAIL %s a=%h b=%h sel=%b cm=%b fa=%b: res=%h neg=%b expected res=%h neg=%b",
               tag, x, y, s, c, f, r, n, er, en);
    end
  endtask

  initial begin
    a = 0; b = 0; sel = 0; cm = 0; fa = 0;
    run(0, 0, 3'b000, 0, 0, "R9 idle zero");
    run(32'd5, 32'd7, 3'b011, 0, 0, "R1 add");
    run(32'd5, 32'd7, 3'b010, 0, 0, "R1 sub negative");
    run(32'h8000_0000, 32'd1, 3'b010, 0, 0, "R2 R8 sub wrap overflow");
    run(32'h7fff_ffff, 32'h8000_0000, 3'b010, 0, 0, "R2 R8 sub overflow positive");
    run(32'h7fff_ffff, 32'd1, 3'b011, 0, 0, "R8 add overflow");
    run(32'hf0f0_1234, 32'h0ff0_ffff, 3'b110, 0, 0, "R3 and");
    run(32'hf0f0_1234, 32'h0ff0_ffff, 3'b101, 0, 0, "R3 or");
    run(32'hf0f0_1234, 32'h0ff0_ffff, 3'b100, 0, 0, "R3 xor");
    run(32'h1234, 32'h5678, 3'b001, 0, 0, "R9 code 001");
    run(32'h1234, 32'h5678, 3'b111, 0, 0, "R9 code 111");
    run(32'h1000, 32'h24, 3'b110, 0, 1, "R4 forced add over and");
    run(32'h1000, 32'h24, 3'b001, 1, 1, "R4 forced add over compare");
    run(32'hffff_fffc, 32'd8, 3'b010, 0, 1, "R4 forced add over sub");
    for (int s = 0; s < 8; s++) begin
      run(32'd3, 32'd3, 3'(s), 1, 0, "R6 R7 equal");
      run(32'hffff_fff0, 32'd2, 3'(s), 1, 0, "R6 R7 signed less");
      run(32'h7fff_ffff, 32'h8000_0000, 3'(s), 1, 0, "R5 R6 greater overflow");
      run(32'h8000_0000, 32'h7fff_ffff, 3'(s), 1, 0, "R6 R8 less overflow");
    end
    for (int i = 0; i < 400; i++)
      run($urandom, (i % 5 == 0) ? 32'h8000_0000 : $urandom, 3'($urandom),
          1'($urandom), (i % 7 == 0), "R1 R3 R6 random");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule